// File: doc/BRIEF.md
# Segmented Thermometer Encoder and 4:1 Serializer

This block sits on the digital path in front of a 6-bit segmented current-steering converter. Once every four fast-clock cycles it takes a word of four 6-bit samples in parallel. Each sample is cut into three 2-bit groups (high, middle, low). One small encoder per group turns the group into three equally weighted thermometer lines, so one word gives 36 lines. A two-stage 2:1 multiplexer tree then turns these 36 lines into 9 output lanes that carry one sample per fast cycle, in sample order.

All logic runs on the fast clock. The slow word rate comes from a four-state phase sequencer with states `PH_A`, `PH_B`, `PH_C` and `PH_D`. The only transitions are `PH_A`→`PH_B`, `PH_B`→`PH_C`, `PH_C`→`PH_D` and `PH_D`→`PH_A`, and reset forces `PH_A`. The sequencer drives each stage as follows:

- In `PH_A` it raises `word_take`. The input word is captured into the encode register at that edge. The same edge loads the upper sample pair into the first mux stage.
- In `PH_B` it refreshes the hold stage, which retimes the encoded word.
- In `PH_C` it loads the lower sample pair into the first mux stage.
- The output stage alternates between the two first-stage paths on every edge.

The feeding logic places a new word on `din` while `word_take` is high and may leave anything there in the other cycles.

Top module: `seg_therm_serializer`

## Requirements
- R1: A 2-bit group value v drives its three lines so that exactly the lowest v lines are 1: 0→000, 1→001, 2→011, 3→111 (line order [2:0]).
- R2: Within a 9-bit output lane word, sample bits [1:0] map to lanes [2:0], bits [3:2] map to lanes [5:3], and bits [5:4] map to lanes [8:6].
- R3: Sample k of a word occupies `din[6k+5:6k]`. The four samples of one word appear on `lanes` in four consecutive fast cycles, in the order 0, 1, 2, 3.
- R4: `din` is sampled at the rising edge that ends a cycle in which `word_take` is 1. Sample 0 of that word is on `lanes` after the third rising edge that follows (a latency of 3 fast cycles). Samples 1, 2 and 3 follow at 4, 5 and 6 cycles.
- R5: After reset is released, `word_take` is 1 in the first cycle and then in exactly one cycle out of every four.
- R6: While `rst` is high (synchronous, active high), `lanes` is driven to 0 from the first edge onward and `word_take` stays 1. After release the pipeline still emits zeros until the first captured word arrives.
- R7: Values on `din` during cycles with `word_take` low have no effect on `lanes`.
- R8: Words taken on consecutive strobes produce an unbroken lane stream: sample 3 of one word is followed in the very next cycle by sample 0 of the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (serial-rate) clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 24 | Four parallel 6-bit samples; sample k in bits [6k+5:6k] |
| word_take | output | 1 | High in the cycle whose closing edge captures `din` |
| lanes | output | 9 | Thermometer lanes of the sample being sent this cycle |

## Verification
Two things happen at the same edge. The capture of a new word lands while the first mux stage is loading the upper pair of the previous word and the output stage is sending that word's sample 1. Back-to-back words with distinct per-sample values provoke this. Garbage is driven on `din` in every non-strobe cycle, and every output cycle is compared with a stream predicted from the strobed words alone. A reset asserted in the middle of a frame, with samples still in flight, is the second collision. It is judged by all-zero lanes during and just after reset, and by the strobe cadence restarting in its first cycle.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int SAMPLES   = 4;
    localparam int SAMPLE_W  = 6;
    localparam int SEG_W     = 2;
    localparam int SEGS      = SAMPLE_W / SEG_W;
    localparam int THERM_W   = (1 << SEG_W) - 1;
    localparam int LANES     = SEGS * THERM_W;
    localparam int BUS_W     = SAMPLES * SAMPLE_W;
    localparam int THERM_BUS = SAMPLES * LANES;

    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2,
        PH_D = 2'd3
    } phase_t;

    typedef struct packed {
        logic take;
        logic hold_en;
        logic s1_en;
        logic s1_upper;
        logic s2_pick_b;
    } ctl_t;
endpackage

// File: rtl/seg_therm_enc.sv
module seg_therm_enc #(
    parameter int IN_W  = 2,
    localparam int OUT_W = (1 << IN_W) - 1
) (
    input  logic [IN_W-1:0]  grp,
    output logic [OUT_W-1:0] therm
);
    for (genvar k = 0; k < OUT_W; k++) begin : g_line
        assign therm[k] = (32'(grp) > k);
    end
endmodule

// File: rtl/seg_sample_enc.sv
module seg_sample_enc
    import seg_pkg::*;
(
    input  logic [SAMPLE_W-1:0] sample,
    output logic [LANES-1:0]    therm
);
    for (genvar g = 0; g < SEGS; g++) begin : g_grp
        seg_therm_enc #(.IN_W(SEG_W)) u_grp (
            .grp   (sample[g*SEG_W +: SEG_W]),
            .therm (therm[g*THERM_W +: THERM_W])
        );
    end
endmodule

// File: rtl/seg_mux2_reg.sv
module seg_mux2_reg #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         sel,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= sel ? b : a;
        end
    end
endmodule

// File: rtl/seg_phase_fsm.sv
module seg_phase_fsm
    import seg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output ctl_t ctl
);
    phase_t state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_A;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        ctl      = '0;
        state_nx = state;
        unique case (state)
            PH_A: begin
                ctl.take      = 1'b1;
                ctl.s1_en     = 1'b1;
                ctl.s1_upper  = 1'b1;
                ctl.s2_pick_b = 1'b1;
                state_nx      = PH_B;
            end
            PH_B: begin
                ctl.hold_en   = 1'b1;
                state_nx      = PH_C;
            end
            PH_C: begin
                ctl.s1_en     = 1'b1;
                ctl.s2_pick_b = 1'b1;
                state_nx      = PH_D;
            end
            PH_D: begin
                state_nx      = PH_A;
            end
        endcase
    end
endmodule

// File: rtl/seg_therm_serializer.sv
module seg_therm_serializer
    import seg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] din,
    output logic             word_take,
    output logic [LANES-1:0] lanes
);
    ctl_t                 ctl;
    logic [THERM_BUS-1:0] enc_d;
    logic [THERM_BUS-1:0] enc_q;
    logic [THERM_BUS-1:0] hold_q;
    logic [LANES-1:0]     s1a;
    logic [LANES-1:0]     s1b;

    seg_phase_fsm u_fsm (
        .clk (clk),
        .rst (rst),
        .ctl (ctl)
    );

    assign word_take = ctl.take;

    for (genvar s = 0; s < SAMPLES; s++) begin : g_smp
        seg_sample_enc u_enc (
            .sample (din[s*SAMPLE_W +: SAMPLE_W]),
            .therm  (enc_d[s*LANES +: LANES])
        );
    end

    // capture flop, then retiming hold stage
    always_ff @(posedge clk) begin
        if (rst) begin
            enc_q  <= '0;
            hold_q <= '0;
        end else begin
            if (ctl.take) begin
                enc_q <= enc_d;
            end
            if (ctl.hold_en) begin
                hold_q <= enc_q;
            end
        end
    end

    // first stage: path a carries samples 0/2, path b carries 1/3
    seg_mux2_reg #(.W(LANES)) u_s1a (
        .clk (clk), .rst (rst), .en (ctl.s1_en), .sel (ctl.s1_upper),
        .a (hold_q[0*LANES +: LANES]), .b (hold_q[2*LANES +: LANES]), .q (s1a)
    );
    seg_mux2_reg #(.W(LANES)) u_s1b (
        .clk (clk), .rst (rst), .en (ctl.s1_en), .sel (ctl.s1_upper),
        .a (hold_q[1*LANES +: LANES]), .b (hold_q[3*LANES +: LANES]), .q (s1b)
    );
    // second stage: interleave the two paths every cycle
    seg_mux2_reg #(.W(LANES)) u_s2 (
        .clk (clk), .rst (rst), .en (1'b1), .sel (ctl.s2_pick_b),
        .a (s1a), .b (s1b), .q (lanes)
    );
endmodule

// File: rtl/seg_therm_chk.sv
module seg_therm_chk (
    input logic        clk,
    input logic        rst,
    input logic [23:0] din,
    input logic        word_take,
    input logic [8:0]  lanes
);
    logic [1:0] since;
    logic [2:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= 2'd0;
            age   <= 3'd0;
        end else begin
            since <= since + 2'd1;
            if (age != 3'd7) age <= age + 3'd1;
        end
    end

    function automatic logic [2:0] grp3(input logic [1:0] v);
        return {v == 2'd3, v >= 2'd2, v != 2'd0};
    endfunction

    function automatic logic [8:0] smp9(input logic [5:0] s);
        return {grp3(s[5:4]), grp3(s[3:2]), grp3(s[1:0])};
    endfunction

    function automatic logic is_therm(input logic [2:0] t);
        return (t == 3'b000) || (t == 3'b001) || (t == 3'b011) || (t == 3'b111);
    endfunction

    AST_GROUP_THERM: assert property (@(posedge clk) disable iff (rst)
        is_therm(lanes[2:0]) && is_therm(lanes[5:3]) && is_therm(lanes[8:6])); // R1

    AST_TAKE_CADENCE: assert property (@(posedge clk) disable iff (rst)
        word_take == (since == 2'd0)); // R5

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> (lanes == 9'd0)); // R6

    AST_FIRST_SAMPLE_LAT: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd4 && $past(word_take, 4)) |-> (lanes == smp9($past(din[5:0], 4)))); // R4

    AST_LAST_SAMPLE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (age == 3'd7 && $past(word_take, 7)) |-> (lanes == smp9($past(din[23:18], 7)))); // R3
endmodule

bind seg_therm_serializer seg_therm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .din       (din),
    .word_take (word_take),
    .lanes     (lanes)
);

// File: tb/sim_seg_therm_serializer.sv
module sim_seg_therm_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    localparam logic [23:0] VEC [NVEC] = '{
        24'h000000, 24'hFFFFFF, 24'h0C4100, 24'h030C30,
        24'h3FFFC0, 24'h15B6DB, 24'h2AAAAA, 24'h123456,
        24'hFC0FC0, 24'h01F03E, 24'h249249, 24'h38E38E
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] din = '0;
    logic        word_take;
    logic [8:0]  lanes;

    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    logic [1:0]  ph = 2'd0;
    logic [8:0]  expq [64];
    logic [23:0] junk = 24'h5A5A5A;

    seg_therm_serializer u0 (
        .clk (clk), .rst (rst), .din (din),
        .word_take (word_take), .lanes (lanes)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) ph = 2'd0; else ph = ph + 2'd1;
    end

    function automatic logic [2:0] th(input logic [1:0] v);
        case (v)
            2'd0: return 3'b000;
            2'd1: return 3'b001;
            2'd2: return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    function automatic logic [8:0] lane_word(input logic [5:0] s);
        return {th(s[5:4]), th(s[3:2]), th(s[1:0])};
    endfunction

    task automatic chk9(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic step_check();
        @(negedge clk);
        chk9("R1 R2 R3 R4 R7 R8 lane stream", lanes, expq[cyc % 64]);
        chk1("R5 strobe cadence", word_take, ph == 2'd0);
    endtask

    task automatic send_word(input logic [23:0] v);
        do begin
            step_check();
            if (!word_take) begin
                junk = {junk[22:0], junk[23] ^ junk[18] ^ junk[0]};
                din  = junk;   // R7: must not reach the lanes
            end
        end while (!word_take);
        din = v;
        for (int i = 0; i < 4; i++)
            expq[(cyc + 4 + i) % 64] = lane_word(v[6*i +: 6]);
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1;
        din = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk9("R6 lanes zero in reset", lanes, 9'd0);
            chk1("R6 strobe high in reset", word_take, 1'b1);
        end
        for (int i = 0; i < 64; i++) expq[i] = '0;
        rst = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) expq[i] = '0;
        do_reset(4);
        // table of words, sent back to back
        for (int i = 0; i < NVEC; i++) send_word(VEC[i]);
        for (int i = 0; i < 3; i++) send_word(24'h000000);
        // R8: alternate extremes so every word boundary toggles all lanes
        send_word(24'hFFFFFF);
        send_word(24'h000000);
        send_word(24'hFFFFFF);
        send_word(24'h000000);
        // R6: reset with samples still in flight
        send_word(24'h3FFFFF);
        @(negedge clk);
        do_reset(3);
        // R5: right after release the strobe is already high
        chk1("R5 strobe first cycle after release", word_take, 1'b1);
        for (int i = 0; i < 4; i++) begin
            step_check();
        end
        send_word(24'h0A50F3);
        send_word(24'h3C3C3C);
        for (int i = 0; i < 3; i++) send_word(24'h000000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule